// File: doc/BRIEF.md
# Sectioned Programmable AND-Array Logic

This block is a small field-configurable sum-of-products device. It has eight logic inputs, eight outputs and eight sections. Each section owns eight product terms that feed one fixed OR gate, and that OR gate drives the section's output. Only the AND plane is configurable. A product term belongs to exactly one section, so sections never share terms.

The AND plane is loaded one term at a time through a write port, and is cleared by reset. Each term can use the true or the complemented form of every input. It can also use the result of any lower-numbered section as a literal. This lets a function built in one section be reused inside another section in the same cycle. A connection from a section to its own result, or to the result of a higher section, is dropped when the term is loaded, so no combinational loop can form. The eight section results are captured in an output register once per clock.

Top module: `pal_array`

## Requirements
- R1: While `rst` is high at a clock edge, `pal_out` becomes 0 and every stored term word is cleared.
- R2: A term word at `prog_addr` = section*8 + term holds 32 literal bits. Bit 2j selects the true form and bit 2j+1 the complemented form of literal j. Literals 0..7 are `pal_in[0..7]` and literals 8..15 are section results 0..7.
- R3: A term word with no bit set contributes 0 to its section, so an unprogrammed device drives all outputs low.
- R4: A term is the AND of all its selected literals, so a term that selects both forms of one input is always 0. A section result is the OR of its eight terms.
- R5: Writing a term changes only the result of the section that owns that address.
- R6: A term may use the result of a lower-numbered section as a literal, in either polarity.
- R7: On a write, every feedback bit that names the term's own section or a higher-numbered section is stored as 0. A term whose only selections are such bits therefore behaves as unconnected.
- R8: `pal_out` shows the function of the `pal_in` value and configuration present at the previous rising edge. With steady inputs and no writes, it stays steady.
- R9: While `prog_we` is low, `prog_data` and `prog_addr` leave the configuration unchanged.
- R10: Feedback ripples through a chain of sections within one cycle, so a result that depends on a section two links back settles before the same output capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Term write strobe |
| prog_addr | input | 6 | Term index: section*8 + term |
| prog_data | input | 32 | Literal selection word for the addressed term |
| pal_in | input | 8 | Logic inputs |
| pal_out | output | 8 | Registered section results |

## Verification
The device is first exercised unprogrammed, which tells an empty term evaluating to 0 apart from one evaluating to 1. Single-section functions are then walked through every combination of their literals, which separates true from complemented selection and AND from OR behaviour. Terms using feedback, forbidden self or upward feedback, a three-section ripple chain, a write with the strobe low and an overwritten term each get vectors that distinguish the intended outcome from the likely wrong one. The run ends with a sweep of all 256 input values against an independent model of the loaded configuration.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Polarity of a literal selection inside a term word
  typedef enum logic {
    POL_TRUE  = 1'b0,
    POL_COMPL = 1'b1
  } pal_pol_e;

  // Bit position of literal 'lit' with polarity 'pol' inside a term word
  function automatic int lit_pos(input int lit, input pal_pol_e pol);
    return 2 * lit + int'(pol);
  endfunction

endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 8,
  parameter int N_TERMS = 8,
  localparam int LIT_W   = 2 * (N_IN + N_OUT),
  localparam int N_TOT   = N_OUT * N_TERMS,
  localparam int ADDR_W  = $clog2(N_TOT),
  localparam int TERM_AW = $clog2(N_TERMS),
  localparam int SEC_W   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LIT_W-1:0]        wr_data,
  output logic [N_TOT*LIT_W-1:0]  cfg_flat
);
  import pal_pkg::*;

  logic [LIT_W-1:0] words [N_TOT];
  logic [LIT_W-1:0] keep_mask;
  logic [SEC_W-1:0] wr_sec;

  assign wr_sec = SEC_W'(wr_addr >> TERM_AW);

  // Inputs are always allowed; feedback only from strictly lower sections
  always_comb begin
    keep_mask = '0;
    for (int j = 0; j < N_IN; j++) begin
      keep_mask[lit_pos(j, POL_TRUE)]  = 1'b1;
      keep_mask[lit_pos(j, POL_COMPL)] = 1'b1;
    end
    for (int k = 0; k < N_OUT; k++) begin
      keep_mask[lit_pos(N_IN + k, POL_TRUE)]  = (SEC_W'(k) < wr_sec);
      keep_mask[lit_pos(N_IN + k, POL_COMPL)] = (SEC_W'(k) < wr_sec);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_TOT; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[wr_addr] <= wr_data & keep_mask;
    end
  end

  for (genvar i = 0; i < N_TOT; i++) begin : g_flat
    assign cfg_flat[i*LIT_W +: LIT_W] = words[i];
  end

endmodule

// File: rtl/pal_term.sv
module pal_term #(
  parameter int N_LIT = 16,
  localparam int LIT_W = 2 * N_LIT
) (
  input  logic [LIT_W-1:0] sel,
  input  logic [N_LIT-1:0] lits,
  output logic             prod
);
  import pal_pkg::*;

  logic [N_LIT-1:0] pass;

  for (genvar j = 0; j < N_LIT; j++) begin : g_lit
    assign pass[j] = ~(sel[lit_pos(j, POL_TRUE)]  & ~lits[j])
                   & ~(sel[lit_pos(j, POL_COMPL)] &  lits[j]);
  end

  // An empty term is forced low so unused terms never raise an output
  assign prod = (|sel) & (&pass);

endmodule

// File: rtl/pal_section.sv
module pal_section #(
  parameter int N_LIT   = 16,
  parameter int N_TERMS = 8,
  localparam int LIT_W  = 2 * N_LIT
) (
  input  logic [N_TERMS*LIT_W-1:0] sec_cfg,
  input  logic [N_LIT-1:0]         lits,
  output logic                     result
);
  logic [N_TERMS-1:0] prods;

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    pal_term #(.N_LIT(N_LIT)) i_term (
      .sel  (sec_cfg[t*LIT_W +: LIT_W]),
      .lits (lits),
      .prod (prods[t])
    );
  end

  assign result = |prods;

endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 8,
  parameter int N_TERMS = 8,
  localparam int N_LIT   = N_IN + N_OUT,
  localparam int LIT_W   = 2 * N_LIT,
  localparam int N_TOT   = N_OUT * N_TERMS,
  localparam int ADDR_W  = $clog2(N_TOT),
  localparam int SEC_CW  = N_TERMS * LIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [LIT_W-1:0]  prog_data,
  input  logic [N_IN-1:0]   pal_in,
  output logic [N_OUT-1:0]  pal_out
);
  logic [N_TOT*LIT_W-1:0] cfg_flat;
  logic [N_OUT-1:0]       sec_val;

  pal_cfg_store #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERMS(N_TERMS)) i_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (prog_we),
    .wr_addr  (prog_addr),
    .wr_data  (prog_data),
    .cfg_flat (cfg_flat)
  );

  for (genvar s = 0; s < N_OUT; s++) begin : g_sec
    logic [N_OUT-1:0] fb_view;
    // Only lower sections are wired in, so the netlist has no loop
    for (genvar k = 0; k < N_OUT; k++) begin : g_fb
      if (k < s) begin : g_live
        assign fb_view[k] = sec_val[k];
      end else begin : g_tied
        assign fb_view[k] = 1'b0;
      end
    end

    pal_section #(.N_LIT(N_LIT), .N_TERMS(N_TERMS)) i_section (
      .sec_cfg (cfg_flat[s*SEC_CW +: SEC_CW]),
      .lits    ({fb_view, pal_in}),
      .result  (sec_val[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pal_out <= '0;
    else     pal_out <= sec_val;
  end

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
  parameter int N_IN    = 8,
  parameter int N_OUT   = 8,
  parameter int N_TERMS = 8,
  localparam int N_LIT   = N_IN + N_OUT,
  localparam int LIT_W   = 2 * N_LIT,
  localparam int N_TOT   = N_OUT * N_TERMS,
  localparam int ADDR_W  = $clog2(N_TOT),
  localparam int TERM_AW = $clog2(N_TERMS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   prog_we,
  input logic [ADDR_W-1:0]      prog_addr,
  input logic [LIT_W-1:0]       prog_data,
  input logic [N_IN-1:0]        pal_in,
  input logic [N_OUT-1:0]       pal_out,
  input logic [N_TOT*LIT_W-1:0] cfg_flat
);
  logic              seen_wr;
  logic [ADDR_W-1:0] q_addr;
  logic [LIT_W-1:0]  q_data;
  logic [LIT_W-1:0]  q_word;
  logic [LIT_W-1:0]  q_allow;
  int                q_sec;

  always_ff @(posedge clk) begin
    if (rst) seen_wr <= 1'b0;
    else if (prog_we) seen_wr <= 1'b1;
    q_addr <= prog_addr;
    q_data <= prog_data;
  end

  assign q_word = cfg_flat[q_addr*LIT_W +: LIT_W];
  assign q_sec  = int'(q_addr) / N_TERMS;

  always_comb begin
    q_allow = '0;
    q_allow[2*N_IN-1:0] = '1;
    for (int k = 0; k < N_OUT; k++)
      if (k < q_sec) q_allow[2*(N_IN+k) +: 2] = 2'b11;
  end

  // R1: output is clear in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pal_out == '0));

  // R3: with nothing written since reset the outputs stay low
  p_empty_low_r3: assert property (@(posedge clk) disable iff (rst)
    !seen_wr |-> (pal_out == '0));

  // R8: steady inputs and no writes give a steady output
  p_steady_out_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!prog_we) && $stable(pal_in) && !prog_we) |=> $stable(pal_out));

  // R9: no strobe, no configuration change
  p_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    !prog_we |=> $stable(cfg_flat));

  // R7: forbidden feedback bits never land in storage
  p_fb_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    prog_we |=> ((q_word & ~q_allow) == '0));

  // R2: permitted bits are stored as written
  p_word_kept_r2: assert property (@(posedge clk) disable iff (rst)
    prog_we |=> (((q_word ^ q_data) & q_allow) == '0));

endmodule

bind pal_array pal_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERMS(N_TERMS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .prog_we   (prog_we),
  .prog_addr (prog_addr),
  .prog_data (prog_data),
  .pal_in    (pal_in),
  .pal_out   (pal_out),
  .cfg_flat  (cfg_flat)
);

// File: tb/test_pal_array.sv
module test_pal_array;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [7:0]  pal_in = '0;
  logic [7:0]  pal_out;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model [64];
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  pal_array i_pal_array (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pal_in(pal_in), .pal_out(pal_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void check(string tag, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endfunction

  // R2/R7: stored word keeps inputs and only feedback from lower sections
  function automatic logic [31:0] allowed(int sec);
    logic [31:0] m = 32'h0000_FFFF;
    for (int k = 0; k < 8; k++) if (k < sec) m[16+2*k +: 2] = 2'b11;
    return m;
  endfunction

  // R3/R4/R6/R10: evaluate sections in order with feedback
  function automatic logic [7:0] model_eval(logic [7:0] x);
    logic [7:0] r = '0;
    for (int s = 0; s < 8; s++) begin
      logic hit = 1'b0;
      for (int t = 0; t < 8; t++) begin
        logic [31:0] w = model[s*8+t];
        logic p = (w != 0);
        for (int j = 0; j < 16; j++) begin
          logic v = (j < 8) ? x[j] : r[j-8];
          if (w[2*j] && !v) p = 1'b0;
          if (w[2*j+1] && v) p = 1'b0;
        end
        hit = hit | p;
      end
      r[s] = hit;
    end
    return r;
  endfunction

  task automatic prog(int a, logic [31:0] d, logic we);
    @(negedge clk);
    prog_we = we; prog_addr = 6'(a); prog_data = d;
    if (we) model[a] = d & allowed(a / 8);
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic apply(logic [7:0] x, string tag);
    @(negedge clk);
    pal_in = x;
    exp_q.push_back(model_eval(x));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Scoreboard monitor: result of the vector latched at this edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) check(tag_q.pop_front(), pal_out, exp_q.pop_front());
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    pal_in = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 output during reset", pal_out, 8'h00);
    rst = 1'b0;
    apply(8'hFF, "R1 R3 unprogrammed all ones");
    apply(8'h00, "R3 unprogrammed all zeros");
    apply(8'hA5, "R3 unprogrammed mixed");
    drain();

    // s0 t0 = in0 & ~in1 ; s0 t1 = in7
    prog(0, 32'h0000_0009, 1'b1);
    for (int v = 0; v < 4; v++) apply(8'(v), "R2 R4 true/complement literals");
    prog(1, 32'h0000_4000, 1'b1);
    apply(8'h80, "R4 OR of second term");
    apply(8'h82, "R4 OR with first term off");
    drain();

    // s1 t0 = in2 & in3
    prog(8, 32'h0000_0050, 1'b1);
    apply(8'h0C, "R5 section1 only");
    apply(8'h0D, "R5 sections 0 and 1");
    drain();

    // s2 t0 = fb0 ; s2 t1 = ~fb1 & in4
    prog(16, 32'h0001_0000, 1'b1);
    prog(17, 32'h0008_0100, 1'b1);
    apply(8'h01, "R6 true feedback");
    apply(8'h10, "R6 complemented feedback");
    apply(8'h1C, "R6 complemented feedback blocked");
    drain();

    // s3 t0 = fb3 & in5 (fb3 dropped) ; s3 t1 = ~fb5 only (dropped)
    prog(24, 32'h0040_0400, 1'b1);
    prog(25, 32'h0800_0000, 1'b1);
    apply(8'h20, "R7 own feedback dropped");
    apply(8'h00, "R7 upward-only term inert");
    drain();

    // s4 t0 = fb2 ; s5 t0 = fb4 & in6
    prog(32, 32'h0010_0000, 1'b1);
    prog(40, 32'h0100_1000, 1'b1);
    apply(8'h41, "R10 ripple chain high");
    apply(8'h40, "R10 ripple chain low");
    drain();

    // strobe low write must not land ; s7 t0 = in0 & ~in0
    prog(48, 32'h0000_0001, 1'b0);
    prog(56, 32'h0000_0003, 1'b1);
    apply(8'h01, "R9 R4 idle write and contradictory term");
    drain();

    // R8: back-to-back vectors line up one cycle later
    apply(8'h01, "R8 pipeline a");
    apply(8'h80, "R8 pipeline b");
    apply(8'h00, "R8 pipeline c");
    drain();

    prog(1, 32'h0000_0000, 1'b1);
    apply(8'h80, "R5 overwritten term removed");
    drain();

    for (int v = 0; v < 256; v++) apply(8'(v), "R4 R6 full sweep");
    drain();
    finish_run();
  end

endmodule